// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block resolves relative branches for an 8-bit processor core. For each presented branch it takes the opcode, the low nibble of the condition-code register, the address of the branch instruction and the signed displacement. It returns one registered result a clock later: whether the branch is taken, and the address execution continues from.

Sixteen conditions are selected by the low opcode nibble. They cover the trivial always and never cases, single flag tests, unsigned comparisons built from carry and zero, and signed comparisons built from negative xor overflow. A short branch is two bytes long and carries an 8-bit displacement. A long branch is four bytes long, including its prefix, and carries a 16-bit displacement. The caller marks it with a separate flag. In both forms the displacement is added to the address that follows the instruction, and the sum wraps modulo 2^ADDR_W.

Top module: `brc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_taken` and `out_next_pc` are all cleared to zero at that edge.
- R2: `out_valid` rises exactly one cycle after a cycle with `in_valid` high. In a cycle with `in_valid` low, `out_taken` and `out_next_pc` keep their previous values.
- R3: Opcode 20h is always taken and opcode 21h is never taken, whatever the flags are.
- R4: Flags are `in_flags` bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. Opcode 22h is taken when C and Z are both 0. Opcode 23h is taken when C or Z is 1.
- R5: Opcode 24h is taken on C=0 and 25h on C=1. Opcode 26h is taken on Z=0 and 27h on Z=1.
- R6: Opcode 28h is taken on V=0 and 29h on V=1. Opcode 2Ah is taken on N=0 and 2Bh on N=1.
- R7: Opcode 2Ch is taken when N xor V is 0, and 2Dh when N xor V is 1.
- R8: Opcode 2Eh is taken when Z or (N xor V) is 0, and 2Fh when it is 1.
- R9: A taken short branch (`in_long`=0) goes to `in_pc`+2 plus the sign-extended `in_offset[7:0]`. Bits 15:8 of `in_offset` have no effect.
- R10: A taken long branch (`in_long`=1) goes to `in_pc`+4 plus the 16-bit `in_offset`, modulo 65536.
- R11: A branch that is not taken gives `in_pc`+2 in short form and `in_pc`+4 in long form.
- R12: An opcode whose upper nibble is not 2h is never taken and gives the fall-through address of R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_long | input | 1 | Long form (4-byte instruction, 16-bit offset) |
| in_opcode | input | 8 | Branch opcode |
| in_flags | input | 4 | N, Z, V, C flags (bit 3 down to bit 0) |
| in_pc | input | 16 | Address of the branch instruction |
| in_offset | input | 16 | Signed displacement (low byte only in short form) |
| out_valid | output | 1 | Result available |
| out_taken | output | 1 | Branch is taken |
| out_next_pc | output | 16 | Next program counter |

## Verification
The only state in this block is the single output register stage, so a fault shows on `out_taken` or `out_next_pc` in the very cycle after the branch is presented. There is no delayed symptom. A wrong condition decode appears as an inverted taken bit for a specific opcode and flag combination, which is why all 256 pairs of condition and flags are checked. A wrong adder or sign extension appears as a target that is off by a fixed amount or by 256. Displacements near the sign boundaries and addresses near the wrap point bring these errors out.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Flag positions inside the condition nibble
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  // Upper opcode nibble shared by every relative branch
  localparam logic [3:0] BR_GROUP = 4'h2;

  // Condition families: opcode bits 3:1; bit 0 inverts the family
  typedef enum logic [2:0] {
    FAM_ALWAYS = 3'd0,
    FAM_HIGHER = 3'd1,
    FAM_CARRY  = 3'd2,
    FAM_ZERO   = 3'd3,
    FAM_OVFL   = 3'd4,
    FAM_SIGN   = 3'd5,
    FAM_GE     = 3'd6,
    FAM_GT     = 3'd7
  } cond_fam_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] code,
  input  logic [3:0] flags,
  output logic       pass
);

  flags_t    f;
  cond_fam_t fam;
  logic      base;
  logic      sgn_lt;

  assign f      = flags_t'(flags);
  assign fam    = cond_fam_t'(code[3:1]);
  assign sgn_lt = f.n ^ f.v;

  // Even codes evaluate the "clear" sense of a family
  always_comb begin
    unique case (fam)
      FAM_ALWAYS: base = 1'b1;
      FAM_HIGHER: base = ~(f.c | f.z);
      FAM_CARRY:  base = ~f.c;
      FAM_ZERO:   base = ~f.z;
      FAM_OVFL:   base = ~f.v;
      FAM_SIGN:   base = ~f.n;
      FAM_GE:     base = ~sgn_lt;
      FAM_GT:     base = ~(f.z | sgn_lt);
      default:    base = 1'b0;
    endcase
  end

  // Odd codes are the complement of their even partner
  assign pass = base ^ code[0];

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int ADDR_W      = 16,
  parameter int SHORT_OFS_W = 8,
  parameter int LONG_OFS_W  = 16,
  parameter int SHORT_LEN   = 2,
  parameter int LONG_LEN    = 4
) (
  input  logic                  is_long,
  input  logic [ADDR_W-1:0]     pc,
  input  logic [LONG_OFS_W-1:0] offset,
  output logic [ADDR_W-1:0]     fall_pc,
  output logic [ADDR_W-1:0]     jump_pc
);

  localparam logic [ADDR_W-1:0] SLEN = ADDR_W'(SHORT_LEN);
  localparam logic [ADDR_W-1:0] LLEN = ADDR_W'(LONG_LEN);

  logic [ADDR_W-1:0] short_ext;
  logic [ADDR_W-1:0] long_ext;
  logic [ADDR_W-1:0] disp;

  // Sign extension of the short displacement
  generate
    if (SHORT_OFS_W < ADDR_W) begin : g_short_ext
      assign short_ext = {{(ADDR_W-SHORT_OFS_W){offset[SHORT_OFS_W-1]}},
                          offset[SHORT_OFS_W-1:0]};
    end else begin : g_short_trunc
      assign short_ext = offset[ADDR_W-1:0];
    end
  endgenerate

  // Long displacement is either full width or sign-extended
  generate
    if (LONG_OFS_W < ADDR_W) begin : g_long_ext
      assign long_ext = {{(ADDR_W-LONG_OFS_W){offset[LONG_OFS_W-1]}}, offset};
    end else begin : g_long_trunc
      assign long_ext = offset[ADDR_W-1:0];
    end
  endgenerate

  assign fall_pc = pc + (is_long ? LLEN : SLEN);
  assign disp    = is_long ? long_ext : short_ext;
  assign jump_pc = fall_pc + disp;

endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
  parameter int ADDR_W      = 16,
  parameter int SHORT_OFS_W = 8,
  parameter int LONG_OFS_W  = 16,
  parameter int SHORT_LEN   = 2,
  parameter int LONG_LEN    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_long,
  input  logic [7:0]            in_opcode,
  input  logic [3:0]            in_flags,
  input  logic [ADDR_W-1:0]     in_pc,
  input  logic [LONG_OFS_W-1:0] in_offset,
  output logic                  out_valid,
  output logic                  out_taken,
  output logic [ADDR_W-1:0]     out_next_pc
);

  import brc_pkg::*;

  logic              cond_pass;
  logic              in_group;
  logic              take_c;
  logic [ADDR_W-1:0] fall_pc;
  logic [ADDR_W-1:0] jump_pc;
  logic [ADDR_W-1:0] next_c;

  brc_cond_eval i_cond (
    .code  (in_opcode[3:0]),
    .flags (in_flags),
    .pass  (cond_pass)
  );

  brc_target #(
    .ADDR_W      (ADDR_W),
    .SHORT_OFS_W (SHORT_OFS_W),
    .LONG_OFS_W  (LONG_OFS_W),
    .SHORT_LEN   (SHORT_LEN),
    .LONG_LEN    (LONG_LEN)
  ) i_target (
    .is_long (in_long),
    .pc      (in_pc),
    .offset  (in_offset),
    .fall_pc (fall_pc),
    .jump_pc (jump_pc)
  );

  assign in_group = (in_opcode[7:4] == BR_GROUP);
  assign take_c   = in_group & cond_pass;
  assign next_c   = take_c ? jump_pc : fall_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken   <= take_c;
        out_next_pc <= next_c;
      end
    end
  end

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int ADDR_W     = 16,
  parameter int LONG_OFS_W = 16,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_long,
  input logic [7:0]            in_opcode,
  input logic [3:0]            in_flags,
  input logic [ADDR_W-1:0]     in_pc,
  input logic [LONG_OFS_W-1:0] in_offset,
  input logic                  out_valid,
  input logic                  out_taken,
  input logic [ADDR_W-1:0]     out_next_pc
);

  localparam logic [ADDR_W-1:0] SLEN = ADDR_W'(SHORT_LEN);
  localparam logic [ADDR_W-1:0] LLEN = ADDR_W'(LONG_LEN);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && out_next_pc == '0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_taken) && $stable(out_next_pc)));

  p_always_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h20) |=> out_taken);

  p_never_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h21) |=> !out_taken);

  p_carry_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h24) |=> (out_taken == !$past(in_flags[0])));

  p_fall_short_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h21 && !in_long) |=>
      (out_next_pc == $past(in_pc) + SLEN));

  p_fall_long_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h21 && in_long) |=>
      (out_next_pc == $past(in_pc) + LLEN));

  p_long_target_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == 8'h20 && in_long) |=>
      (out_next_pc == $past(in_pc) + LLEN + ADDR_W'($past(in_offset))));

  p_non_branch_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode[7:4] != 4'h2) |=> !out_taken);

endmodule

bind brc_unit brc_unit_chk #(
  .ADDR_W     (ADDR_W),
  .LONG_OFS_W (LONG_OFS_W),
  .SHORT_LEN  (SHORT_LEN),
  .LONG_LEN   (LONG_LEN)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_long     (in_long),
  .in_opcode   (in_opcode),
  .in_flags    (in_flags),
  .in_pc       (in_pc),
  .in_offset   (in_offset),
  .out_valid   (out_valid),
  .out_taken   (out_taken),
  .out_next_pc (out_next_pc)
);

// File: tb/test_brc_unit.sv
module test_brc_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_long;
  logic [7:0]  in_opcode;
  logic [3:0]  in_flags;
  logic [15:0] in_pc;
  logic [15:0] in_offset;
  logic        out_valid;
  logic        out_taken;
  logic [15:0] out_next_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  brc_unit i_brc_unit (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_long     (in_long),
    .in_opcode   (in_opcode),
    .in_flags    (in_flags),
    .in_pc       (in_pc),
    .in_offset   (in_offset),
    .out_valid   (out_valid),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc)
  );

  // Expected decision from the condition table (N=3 Z=2 V=1 C=0)
  function automatic logic exp_take(input logic [7:0] op, input logic [3:0] fl);
    logic n, z, v, c;
    n = fl[3]; z = fl[2]; v = fl[1]; c = fl[0];
    if (op[7:4] != 4'h2) return 1'b0;
    case (op[3:0])
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return (c == 1'b0) && (z == 1'b0);
      4'h3: return c || z;
      4'h4: return !c;
      4'h5: return c;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return !v;
      4'h9: return v;
      4'hA: return !n;
      4'hB: return n;
      4'hC: return (n == v);
      4'hD: return (n != v);
      4'hE: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input logic tk, input logic lg,
                                         input logic [15:0] pc, input logic [15:0] ofs);
    logic [15:0] after;
    after = pc + (lg ? 16'd4 : 16'd2);
    if (!tk) return after;
    if (lg) return after + ofs;
    return after + {{8{ofs[7]}}, ofs[7:0]};
  endfunction

  function automatic string req_of(input logic [3:0] code);
    case (code[3:1])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one branch, then sample the registered result at the next falling edge
  task automatic issue(input logic lg, input logic [7:0] op, input logic [3:0] fl,
                       input logic [15:0] pc, input logic [15:0] ofs);
    @(negedge clk);
    in_valid  = 1'b1;
    in_long   = lg;
    in_opcode = op;
    in_flags  = fl;
    in_pc     = pc;
    in_offset = ofs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic lg, input logic [7:0] op,
                         input logic [3:0] fl, input logic [15:0] pc,
                         input logic [15:0] ofs);
    logic tk;
    tk = exp_take(op, fl);
    issue(lg, op, fl, pc, ofs);
    check("R2", "valid", {15'd0, out_valid}, 16'd1);
    check(req, "taken", {15'd0, out_taken}, {15'd0, tk});
    check(req, "next_pc", out_next_pc, exp_pc(tk, lg, pc, ofs));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_long = 1'b0; in_opcode = 8'h00;
    in_flags = 4'h0; in_pc = 16'h0; in_offset = 16'h0;
    repeat (3) @(negedge clk);
    check("R1", "valid after reset", {15'd0, out_valid}, 16'd0);
    check("R1", "taken after reset", {15'd0, out_taken}, 16'd0);
    check("R1", "next_pc after reset", out_next_pc, 16'd0);
    rst = 1'b0;
  endtask

  // All 16 conditions against all 16 flag combinations
  task automatic t_conditions;
    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 16; fl++) begin
        run_one(req_of(4'(code)), 1'b0, {4'h2, 4'(code)}, 4'(fl),
                16'h1000 + 16'(code * 64), 16'h0010);
      end
    end
  endtask

  task automatic t_short_target;
    run_one("R9", 1'b0, 8'h20, 4'h0, 16'h4000, 16'h007F);
    check("R9", "max forward", out_next_pc, 16'h4081);
    run_one("R9", 1'b0, 8'h20, 4'h0, 16'h4000, 16'h0080);
    check("R9", "max backward", out_next_pc, 16'h3F82);
    run_one("R9", 1'b0, 8'h20, 4'h0, 16'h4000, 16'hA5FE);
    check("R9", "upper offset ignored", out_next_pc, 16'h4000);
    run_one("R9", 1'b0, 8'h20, 4'h0, 16'hFFFE, 16'h0005);
    check("R9", "wrap", out_next_pc, 16'h0005);
  endtask

  task automatic t_long_target;
    run_one("R10", 1'b1, 8'h20, 4'h0, 16'h2000, 16'h1234);
    check("R10", "forward", out_next_pc, 16'h3238);
    run_one("R10", 1'b1, 8'h27, 4'h4, 16'h2000, 16'hF000);
    check("R10", "backward", out_next_pc, 16'h1004);
    run_one("R10", 1'b1, 8'h20, 4'h0, 16'hFFF0, 16'h0020);
    check("R10", "wrap", out_next_pc, 16'h0014);
  endtask

  task automatic t_fall_through;
    run_one("R11", 1'b0, 8'h27, 4'h0, 16'h5000, 16'h0040);
    check("R11", "short fall", out_next_pc, 16'h5002);
    run_one("R11", 1'b1, 8'h21, 4'hF, 16'hFFFE, 16'h0040);
    check("R11", "long fall wrap", out_next_pc, 16'h0002);
  endtask

  task automatic t_non_branch;
    run_one("R12", 1'b0, 8'h30, 4'h0, 16'h6000, 16'h0010);
    check("R12", "non-branch fall", out_next_pc, 16'h6002);
    run_one("R12", 1'b1, 8'hA0, 4'h0, 16'h6000, 16'h0010);
    check("R12", "non-branch long fall", out_next_pc, 16'h6004);
  endtask

  task automatic t_hold;
    run_one("R2", 1'b0, 8'h20, 4'h0, 16'h7000, 16'h0004);
    @(negedge clk);
    in_opcode = 8'h21; in_pc = 16'h1111; in_offset = 16'h2222; in_flags = 4'hF;
    @(negedge clk);
    check("R2", "valid low when idle", {15'd0, out_valid}, 16'd0);
    check("R2", "taken held", {15'd0, out_taken}, 16'd1);
    check("R2", "next_pc held", out_next_pc, 16'h7006);
  endtask

  initial begin
    t_reset();
    t_conditions();
    t_short_target();
    t_long_target();
    t_fall_through();
    t_non_branch();
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule